// File: doc/BRIEF.md
# Video Raster Timing and Pixel Output Engine

This block sits in the pixel clock domain of a display controller. From eight programmable lengths it builds the horizontal timing of each line and the vertical timing of each frame. It drives horizontal sync, vertical sync and data-enable, each with a level chosen by software. During every active pixel it takes one pixel word from an upstream pixel buffer and presents it on the output.

When an active pixel falls due and the buffer is empty, the engine flags an underrun. For the rest of that frame it reads nothing more from the buffer and shows the last pixel it sent again for every remaining active position. The flag clears when the frame ends, and the next frame reads the buffer as normal. Single-cycle event pulses mark the start of vertical sync, the end of each frame and the moment an underrun is detected. While the enable input is low the engine holds its counters at the start of sync and keeps every output at its idle level.

Top module: `vid_timing_engine`

## Requirements
- R1: During and right after reset, with all polarity bits clear, hsync, vsync, de, pix_out, buf_pop, every event output and underrun are 0.
- R2: A line is the sync, back porch, active and front porch phases in that order, lasting h_sync_len, h_back_len, h_data_len and h_front_len cycles. The line length is their sum, and hsync is active for h_sync_len cycles of each line.
- R3: A frame is the vertical sync, back porch, active and front porch phases in that order, counted in lines. vsync is active for v_sync_len whole lines. de is active for h_data_len × v_data_len cycles per frame. The first active pixel comes (v_sync_len + v_back_len) × line length + h_sync_len + h_back_len cycles after the first vsync cycle.
- R4: A length field of 0 acts as a length of 1.
- R5: Each polarity bit set makes its signal active-low: bit 0 vsync, bit 1 hsync, bit 2 de. Bit 3 set inverts every bit of pix_out. Bit 4 appears on pclk_invert. Outside active pixels pix_out is 0 before inversion.
- R6: In each active pixel where the buffer is not empty and no underrun is flagged, buf_pop is 1 for exactly that cycle. The popped word appears on pix_out in the next cycle, together with active de.
- R7: When an active pixel falls due with an empty buffer, ev_underrun pulses once and underrun goes high. No further pops happen in that frame. Every remaining active pixel of the frame repeats the last word sent, or 0 if none has been sent since reset.
- R8: underrun is low in the cycle of ev_frame_done, and the following frame pops the buffer normally.
- R9: ev_vsync_start pulses in the first vsync cycle of each frame. ev_frame_done pulses in the last output cycle of each frame, exactly once per frame.
- R10: With enable low, timing stops and, from the next cycle, all syncs and de are at their idle level, with no pop, no event and no underrun. After enable rises, the first output cycle is the start of vertical sync.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Runs the timing when high |
| h_sync_len | input | TW | Horizontal sync length in cycles |
| h_back_len | input | TW | Horizontal back porch length |
| h_data_len | input | TW | Active pixels per line |
| h_front_len | input | TW | Horizontal front porch length |
| v_sync_len | input | TW | Vertical sync length in lines |
| v_back_len | input | TW | Vertical back porch length |
| v_data_len | input | TW | Active lines per frame |
| v_front_len | input | TW | Vertical front porch length |
| polarity | input | 5 | Per-signal inversion controls (see R5) |
| buf_empty | input | 1 | Pixel buffer holds no word |
| buf_data | input | PIX_W | Word at the head of the pixel buffer |
| buf_pop | output | 1 | Takes the head word this cycle |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Data enable |
| pix_out | output | PIX_W | Output pixel |
| pclk_invert | output | 1 | Pixel clock edge select for the pad |
| ev_vsync_start | output | 1 | Pulse at the first vsync cycle |
| ev_frame_done | output | 1 | Pulse at the last cycle of a frame |
| ev_underrun | output | 1 | Pulse when an underrun is detected |
| underrun | output | 1 | Underrun flagged in the current frame |

## Verification
Several timing sets are tried, from a minimal all-ones raster to uneven porches and all-zero fields. Total frame length, sync duty and the offset of the first pixel each separate an error in a different phase or axis. Each set uses a different polarity mix, so a swapped bit or a missing data inversion shows up as a wrong count or wrong pixel. An underrun on the very first pixel separates repeating a word that was never sent from repeating zero. An underrun after three pops, with the buffer refilled at once, separates blocking reads from resuming early. A disable in the middle of the active area checks that the counters restart at sync.

// File: rtl/vid_pkg.sv
package vid_pkg;

    // Phase order inside both a line and a frame; the order is behaviour.
    typedef enum logic [1:0] {
        PH_SYNC  = 2'd0,
        PH_BACK  = 2'd1,
        PH_DATA  = 2'd2,
        PH_FRONT = 2'd3
    } phase_e;

    localparam int NUM_PHASES = 4;
    localparam int NUM_AXES   = 2;
    localparam int AX_H       = 0;
    localparam int AX_V       = 1;

    // Polarity control bit positions.
    localparam int POL_VS   = 0;
    localparam int POL_HS   = 1;
    localparam int POL_DE   = 2;
    localparam int POL_PIX  = 3;
    localparam int POL_PCLK = 4;
    localparam int POL_W    = 5;

endpackage

// File: rtl/vid_axis_ctr.sv
module vid_axis_ctr
    import vid_pkg::*;
#(
    parameter int TW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          step,
    input  logic [TW-1:0] len_sync,
    input  logic [TW-1:0] len_back,
    input  logic [TW-1:0] len_data,
    input  logic [TW-1:0] len_front,
    output phase_e        phase,
    output logic          at_first,
    output logic          at_last
);

    typedef struct packed {
        phase_e        ph;
        logic [TW-1:0] cnt;
    } ctr_t;

    ctr_t          s_d, s_q;
    logic [TW-1:0] cur_len;
    logic [TW-1:0] lim;
    logic          wrap;

    // Length of the current phase; zero counts as one.
    always_comb begin
        unique case (s_q.ph)
            PH_SYNC:  cur_len = len_sync;
            PH_BACK:  cur_len = len_back;
            PH_DATA:  cur_len = len_data;
            default:  cur_len = len_front;
        endcase
        lim  = (cur_len == '0) ? '0 : cur_len - 1'b1;
        wrap = (s_q.cnt == lim);
    end

    always_comb begin
        s_d = s_q;
        if (clr) begin
            s_d.ph  = PH_SYNC;
            s_d.cnt = '0;
        end else if (step) begin
            if (wrap) begin
                s_d.ph  = phase_e'(s_q.ph + 2'd1);
                s_d.cnt = '0;
            end else begin
                s_d.cnt = s_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{ph: PH_SYNC, cnt: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign phase    = s_q.ph;
    assign at_first = (s_q.ph == PH_SYNC) && (s_q.cnt == '0);
    assign at_last  = (s_q.ph == PH_FRONT) && wrap;

endmodule

// File: rtl/vid_pix_stage.sv
module vid_pix_stage
    import vid_pkg::*;
#(
    parameter int PIX_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  phase_e           h_ph,
    input  phase_e           v_ph,
    input  logic             h_first,
    input  logic             v_first,
    input  logic             h_last,
    input  logic             v_last,
    input  logic [POL_W-1:0] pol,
    input  logic             buf_empty,
    input  logic [PIX_W-1:0] buf_data,
    output logic             pop,
    output logic             hs_o,
    output logic             vs_o,
    output logic             de_o,
    output logic [PIX_W-1:0] pix_o,
    output logic             pclk_inv_o,
    output logic             ev_vs_o,
    output logic             ev_fd_o,
    output logic             ev_ur_o,
    output logic             urun_o
);

    typedef struct packed {
        logic             hs;
        logic             vs;
        logic             de;
        logic             pclk_inv;
        logic             ev_vs;
        logic             ev_fd;
        logic             ev_ur;
        logic             urun;
        logic [PIX_W-1:0] pix;
        logic [PIX_W-1:0] last;
    } out_t;

    out_t             o_d, o_q;
    logic             act_pix;
    logic             frame_end;
    logic             starve;
    logic [PIX_W-1:0] raw_pix;

    always_comb begin
        act_pix   = run && (h_ph == PH_DATA) && (v_ph == PH_DATA);
        frame_end = run && h_last && v_last;
        starve    = act_pix && buf_empty && !o_q.urun;
        pop       = act_pix && !buf_empty && !o_q.urun;

        if (!act_pix) begin
            raw_pix = '0;
        end else if (pop) begin
            raw_pix = buf_data;
        end else begin
            raw_pix = o_q.last;
        end

        o_d          = o_q;
        o_d.hs       = (run && (h_ph == PH_SYNC)) ^ pol[POL_HS];
        o_d.vs       = (run && (v_ph == PH_SYNC)) ^ pol[POL_VS];
        o_d.de       = act_pix ^ pol[POL_DE];
        o_d.pclk_inv = pol[POL_PCLK];
        o_d.ev_vs    = run && h_first && v_first;
        o_d.ev_fd    = frame_end;
        o_d.ev_ur    = starve;
        o_d.urun     = run && !frame_end && (o_q.urun || starve);
        o_d.pix      = raw_pix ^ {PIX_W{pol[POL_PIX]}};
        o_d.last     = pop ? buf_data : o_q.last;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            o_q <= '0;
        end else begin
            o_q <= o_d;
        end
    end

    assign hs_o       = o_q.hs;
    assign vs_o       = o_q.vs;
    assign de_o       = o_q.de;
    assign pix_o      = o_q.pix;
    assign pclk_inv_o = o_q.pclk_inv;
    assign ev_vs_o    = o_q.ev_vs;
    assign ev_fd_o    = o_q.ev_fd;
    assign ev_ur_o    = o_q.ev_ur;
    assign urun_o     = o_q.urun;

endmodule

// File: rtl/vid_timing_engine.sv
module vid_timing_engine
    import vid_pkg::*;
#(
    parameter int TW    = 12,
    parameter int PIX_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [TW-1:0]    h_sync_len,
    input  logic [TW-1:0]    h_back_len,
    input  logic [TW-1:0]    h_data_len,
    input  logic [TW-1:0]    h_front_len,
    input  logic [TW-1:0]    v_sync_len,
    input  logic [TW-1:0]    v_back_len,
    input  logic [TW-1:0]    v_data_len,
    input  logic [TW-1:0]    v_front_len,
    input  logic [4:0]       polarity,
    input  logic             buf_empty,
    input  logic [PIX_W-1:0] buf_data,
    output logic             buf_pop,
    output logic             hsync,
    output logic             vsync,
    output logic             de,
    output logic [PIX_W-1:0] pix_out,
    output logic             pclk_invert,
    output logic             ev_vsync_start,
    output logic             ev_frame_done,
    output logic             ev_underrun,
    output logic             underrun
);

    logic [TW-1:0]       ax_len  [NUM_AXES][NUM_PHASES];
    phase_e              ax_ph   [NUM_AXES];
    logic [NUM_AXES-1:0] ax_first;
    logic [NUM_AXES-1:0] ax_last;
    logic [NUM_AXES-1:0] ax_step;

    assign ax_len[AX_H][0] = h_sync_len;
    assign ax_len[AX_H][1] = h_back_len;
    assign ax_len[AX_H][2] = h_data_len;
    assign ax_len[AX_H][3] = h_front_len;
    assign ax_len[AX_V][0] = v_sync_len;
    assign ax_len[AX_V][1] = v_back_len;
    assign ax_len[AX_V][2] = v_data_len;
    assign ax_len[AX_V][3] = v_front_len;

    // The pixel axis steps every enabled cycle; the line axis steps at each line end.
    assign ax_step[AX_H] = enable;
    assign ax_step[AX_V] = enable && ax_last[AX_H];

    for (genvar g = 0; g < NUM_AXES; g++) begin : g_axis
        vid_axis_ctr #(.TW(TW)) u_ctr (
            .clk       (clk),
            .rst_n     (rst_n),
            .clr       (!enable),
            .step      (ax_step[g]),
            .len_sync  (ax_len[g][0]),
            .len_back  (ax_len[g][1]),
            .len_data  (ax_len[g][2]),
            .len_front (ax_len[g][3]),
            .phase     (ax_ph[g]),
            .at_first  (ax_first[g]),
            .at_last   (ax_last[g])
        );
    end

    vid_pix_stage #(.PIX_W(PIX_W)) u_pix (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (enable),
        .h_ph       (ax_ph[AX_H]),
        .v_ph       (ax_ph[AX_V]),
        .h_first    (ax_first[AX_H]),
        .v_first    (ax_first[AX_V]),
        .h_last     (ax_last[AX_H]),
        .v_last     (ax_last[AX_V]),
        .pol        (polarity),
        .buf_empty  (buf_empty),
        .buf_data   (buf_data),
        .pop        (buf_pop),
        .hs_o       (hsync),
        .vs_o       (vsync),
        .de_o       (de),
        .pix_o      (pix_out),
        .pclk_inv_o (pclk_invert),
        .ev_vs_o    (ev_vsync_start),
        .ev_fd_o    (ev_frame_done),
        .ev_ur_o    (ev_underrun),
        .urun_o     (underrun)
    );

endmodule

// File: rtl/vid_timing_engine_chk.sv
module vid_timing_engine_chk #(
    parameter int PIX_W = 24
) (
    input logic             clk,
    input logic             rst_n,
    input logic             enable,
    input logic [4:0]       polarity,
    input logic             buf_empty,
    input logic             buf_pop,
    input logic             vsync,
    input logic             de,
    input logic [PIX_W-1:0] pix_out,
    input logic             ev_vsync_start,
    input logic             ev_frame_done,
    input logic             ev_underrun,
    input logic             underrun
);

    // R6
    pop_needs_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        buf_pop |-> !buf_empty);

    // R6
    pop_then_de_chk: assert property (@(posedge clk) disable iff (!rst_n)
        buf_pop |=> (de != $past(polarity[2])));

    // R7
    starved_no_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        underrun |-> !buf_pop);

    // R7
    starve_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(underrun) |-> ev_underrun);

    // R8
    frame_end_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_frame_done |-> !underrun);

    // R9
    events_apart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ev_vsync_start, ev_frame_done, ev_underrun}));

    // R9
    vs_start_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_vsync_start |-> (vsync != $past(polarity[0])));

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> ((de == $past(polarity[2])) && !ev_vsync_start && !underrun));

endmodule

bind vid_timing_engine vid_timing_engine_chk #(.PIX_W(PIX_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .enable         (enable),
    .polarity       (polarity),
    .buf_empty      (buf_empty),
    .buf_pop        (buf_pop),
    .vsync          (vsync),
    .de             (de),
    .pix_out        (pix_out),
    .ev_vsync_start (ev_vsync_start),
    .ev_frame_done  (ev_frame_done),
    .ev_underrun    (ev_underrun),
    .underrun       (underrun)
);

// File: tb/vid_timing_engine_tb.sv
module vid_timing_engine_tb;

    localparam int PW = 8;
    localparam int TW = 12;
    localparam int NV = 5;
    // h sync, back, data, front, v sync, back, data, front, polarity
    localparam int VEC [NV][9] = '{
        '{2, 1, 4, 1, 1, 1, 2, 1, 0},
        '{1, 1, 1, 1, 1, 1, 1, 1, 15},
        '{3, 2, 5, 2, 2, 1, 3, 1, 2},
        '{0, 0, 2, 0, 0, 0, 1, 0, 1},
        '{4, 3, 8, 3, 2, 2, 4, 2, 20}
    };

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic          rst_n, en;
    logic [TW-1:0] hs, hb, hd, hf, vs, vb, vd, vf;
    logic [4:0]    pol;
    logic          buf_empty, buf_pop;
    logic [PW-1:0] buf_data, pix_out;
    logic          hsync, vsync, de, pclk_invert;
    logic          ev_vsync_start, ev_frame_done, ev_underrun, underrun;

    int            pop_cnt = 0;
    int            limit   = 0;
    logic [PW-1:0] nxt     = 8'd1;
    logic [PW-1:0] lastpop = '0;
    logic          refill  = 1'b0;

    // Pixel buffer model: words 1, 2, 3, ... until the pop limit.
    always @(posedge clk) begin
        if (buf_pop) begin
            pop_cnt <= pop_cnt + 1;
            nxt     <= nxt + 8'd1;
            lastpop <= nxt;
        end
    end
    assign buf_empty = (pop_cnt >= limit);
    assign buf_data  = nxt;

    vid_timing_engine #(.TW(TW), .PIX_W(PW)) u_dut (
        .clk(clk), .rst_n(rst_n), .enable(en),
        .h_sync_len(hs), .h_back_len(hb), .h_data_len(hd), .h_front_len(hf),
        .v_sync_len(vs), .v_back_len(vb), .v_data_len(vd), .v_front_len(vf),
        .polarity(pol), .buf_empty(buf_empty), .buf_data(buf_data),
        .buf_pop(buf_pop), .hsync(hsync), .vsync(vsync), .de(de),
        .pix_out(pix_out), .pclk_invert(pclk_invert),
        .ev_vsync_start(ev_vsync_start), .ev_frame_done(ev_frame_done),
        .ev_underrun(ev_underrun), .underrun(underrun)
    );

    int total = 0;
    int bad   = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int eff(input int w);
        return (w == 0) ? 1 : w;
    endfunction

    int m_len, m_hs, m_vs, m_de, m_fd, m_ur, m_first, m_bad, m_pops, m_stuck;
    logic m_fdlast;

    // Called at the negedge showing ev_vsync_start; returns at the next one.
    task automatic measure();
        int cyc = 0;
        int p0  = pop_cnt;
        logic prev_fd = 1'b0;
        m_hs = 0; m_vs = 0; m_de = 0; m_fd = 0; m_ur = 0;
        m_first = -1; m_bad = 0; m_stuck = 0;
        do begin
            if (hsync != pol[1]) m_hs++;
            if (vsync != pol[0]) m_vs++;
            if (de != pol[2]) begin
                m_de++;
                if (m_first < 0) m_first = cyc;
                if ((pix_out ^ {PW{pol[3]}}) != lastpop) m_bad++;
            end else if ((pix_out ^ {PW{pol[3]}}) != '0) begin
                m_bad++;
            end
            if (ev_frame_done) m_fd++;
            if (ev_frame_done && underrun) m_stuck++;
            if (ev_underrun) begin
                m_ur++;
                if (refill) limit = 1 << 20;
            end
            prev_fd = ev_frame_done;
            @(negedge clk);
            cyc++;
        end while (!ev_vsync_start && cyc < 5000);
        m_len    = cyc;
        m_fdlast = prev_fd;
        m_pops   = pop_cnt - p0;
    endtask

    task automatic set_cfg(input int i);
        hs = TW'(VEC[i][0]); hb = TW'(VEC[i][1]); hd = TW'(VEC[i][2]); hf = TW'(VEC[i][3]);
        vs = TW'(VEC[i][4]); vb = TW'(VEC[i][5]); vd = TW'(VEC[i][6]); vf = TW'(VEC[i][7]);
        pol = 5'(VEC[i][8]);
    endtask

    task automatic restart();
        en = 1'b0;
        @(negedge clk);
        en = 1'b1;
        @(negedge clk);
        chk(ev_vsync_start == 1'b1, "R10 start at sync after enable", int'(ev_vsync_start), 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        en    = 1'b0;
        set_cfg(0);
        repeat (3) @(negedge clk);
        chk({hsync, vsync, de, pix_out, buf_pop, ev_vsync_start, ev_frame_done, ev_underrun, underrun} == '0,
            "R1 outputs in reset", int'(pix_out), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk({hsync, vsync, de, pix_out, buf_pop, ev_vsync_start, ev_frame_done, ev_underrun, underrun} == '0,
            "R1 outputs after reset", int'(pix_out), 0);

        // R7: empty from the first pixel, nothing ever sent -> repeats 0.
        restart();
        measure();
        chk(m_ur == 1, "R7 one underrun pulse", m_ur, 1);
        chk(m_pops == 0, "R7 no pops when starved", m_pops, 0);
        chk(m_bad == 0, "R7 repeats zero before any word", m_bad, 0);
        chk(m_stuck == 0, "R8 flag low at frame end", m_stuck, 0);
        limit = 1 << 20;
        measure();
        chk(m_ur == 0 && m_pops == 8, "R8 next frame reads normally", m_pops, 8);

        // Table walk over timing and polarity sets.
        for (int i = 0; i < NV; i++) begin
            int l, n;
            set_cfg(i);
            l = eff(VEC[i][0]) + eff(VEC[i][1]) + eff(VEC[i][2]) + eff(VEC[i][3]);
            n = eff(VEC[i][4]) + eff(VEC[i][5]) + eff(VEC[i][6]) + eff(VEC[i][7]);
            restart();
            measure();
            chk(m_len == l * n, "R2 R4 frame length", m_len, l * n);
            chk(m_hs == eff(VEC[i][0]) * n, "R2 R5 hsync cycles", m_hs, eff(VEC[i][0]) * n);
            chk(m_vs == eff(VEC[i][4]) * l, "R3 R5 vsync cycles", m_vs, eff(VEC[i][4]) * l);
            chk(m_de == eff(VEC[i][2]) * eff(VEC[i][6]), "R3 R5 de cycles", m_de,
                eff(VEC[i][2]) * eff(VEC[i][6]));
            chk(m_first == (eff(VEC[i][4]) + eff(VEC[i][5])) * l + eff(VEC[i][0]) + eff(VEC[i][1]),
                "R3 R4 first pixel offset", m_first,
                (eff(VEC[i][4]) + eff(VEC[i][5])) * l + eff(VEC[i][0]) + eff(VEC[i][1]));
            chk(m_fd == 1 && m_fdlast, "R9 frame done on last cycle", m_fd, 1);
            chk(m_bad == 0, "R5 R6 pixel stream", m_bad, 0);
            chk(m_pops == m_de && m_ur == 0, "R6 one pop per pixel", m_pops, m_de);
            chk(pclk_invert == pol[4], "R5 pclk select", int'(pclk_invert), int'(pol[4]));
        end

        // R7: underrun after three words, buffer refilled at once.
        set_cfg(0);
        limit  = pop_cnt + 3;
        refill = 1'b1;
        restart();
        measure();
        chk(m_ur == 1, "R7 single underrun event", m_ur, 1);
        chk(m_pops == 3, "R7 no reads after underrun", m_pops, 3);
        chk(m_bad == 0 && m_de == 8, "R7 last word repeated", m_bad, 0);
        chk(m_stuck == 0, "R8 cleared at frame done", m_stuck, 0);
        refill = 1'b0;
        measure();
        chk(m_pops == 8 && m_ur == 0, "R8 reads resume next frame", m_pops, 8);

        // R10: disable in the middle of the active area.
        begin
            int guard = 0;
            int p0;
            while (de == pol[2] && guard < 200) begin
                @(negedge clk);
                guard++;
            end
            en = 1'b0;
            @(negedge clk);
            chk(hsync == pol[1] && vsync == pol[0] && de == pol[2] && !buf_pop && !underrun,
                "R10 idle levels after disable", int'(de), int'(pol[2]));
            p0 = pop_cnt;
            guard = 0;
            for (int k = 0; k < 6; k++) begin
                @(negedge clk);
                if (ev_vsync_start || ev_frame_done || ev_underrun || de != pol[2]) guard++;
            end
            chk(guard == 0 && pop_cnt == p0, "R10 timing stopped", guard, 0);
            en = 1'b1;
            @(negedge clk);
            chk(ev_vsync_start == 1'b1 && vsync != pol[0] && hsync != pol[1],
                "R10 restart at sync", int'(ev_vsync_start), 1);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule